// File: doc/BRIEF.md
# Preloadable 8-bit Reload Timer

This block is an up-counting timer for a small control processor. Software sets a start value and a mode through two register addresses, and the timer then raises a sticky interrupt-request flag each time its count wraps past the all-ones value. Counting advances once every four system clocks. A fixed divide-by-four prescaler sits in front of the counter, and it restarts its phase whenever counting stops.

The data address is shared by two physical registers. A write lands in a hidden reload register and leaves the running count alone. A read returns the live count. When the count leaves FFH, the reload value is copied into the counter, and on that same clock edge the interrupt flag goes high. The flag stays high until software pulses a clear strobe. The control address holds a run-enable bit and a two-bit mode field. Only one mode value (binary 10, internal-clock timing) lets the counter advance. The remaining control bits read back as zero.

Top module: `reload_timer8`

## Requirements
- R1: After reset the count, the reload register and the control register are all zero, so the timer is stopped, and the interrupt flag is low.
- R2: While counting is allowed, the count rises by one on every fourth rising clock edge. The first increment lands on the fourth edge after the edge that enabled counting.
- R3: With `bus_addr` = 0, a write stores `bus_wdata` in the reload register and does not change the count, and a read returns the current count.
- R4: On a counting edge where the count is FFH, the count takes the reload value and the interrupt flag is set on that same edge. The flag never rises on any other edge.
- R5: Control bit 4 is the run enable (1 = run). While it is 0 the count holds, and the prescaler is cleared, so after re-enabling the first increment again comes on the fourth edge.
- R6: Control bits 7:6 form the mode field. Counting happens only when it holds binary 10. Any other value holds the count.
- R7: The interrupt flag stays set until a clock edge with `irq_clr` high. When a clear and an overflow fall on the same edge, the flag stays set.
- R8: With `bus_addr` = 1, a write loads the control register and a read returns mode in bits 7:6, enable in bit 4, and zeros in bits 5 and 3:0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| bus_addr | input | 1 | Register select: 0 = data (reload/count), 1 = control |
| bus_wr | input | 1 | Write strobe, one cycle per write |
| bus_wdata | input | W | Write data |
| bus_rdata | output | W | Read data for the selected address (combinational) |
| irq_clr | input | 1 | Clears the interrupt flag on the next edge |
| irq_flag | output | 1 | Sticky interrupt request raised on count wrap |

## Verification
On every cycle the assertions check several things: a counting edge is never followed directly by another, the count never moves between counting edges, a data write leaves the count alone, a wrap loads the reload value and raises the flag together, and the flag only falls on a clear that does not meet a wrap. Other behaviour needs the bench's scenarios. These include the exact four-edge spacing from an enabling write, the prescaler restarting after a pause, mode values other than binary 10 freezing the timer, and a reload value written mid-count showing up only at the next wrap.

// File: rtl/tmr_pkg.sv
package tmr_pkg;

  localparam int CTRL_W   = 8;
  localparam int EN_BIT   = 4;
  localparam int MODE_LSB = 6;

  typedef enum logic [1:0] {
    MODE_RSV0  = 2'b00,
    MODE_RSV1  = 2'b01,
    MODE_TIMER = 2'b10,
    MODE_RSV3  = 2'b11
  } tmode_e;

  typedef struct packed {
    tmode_e mode;
    logic   run_en;
  } ctrl_t;

  function automatic logic [CTRL_W-1:0] ctrl_pack(ctrl_t c);
    logic [CTRL_W-1:0] v;
    v = '0;
    v[MODE_LSB +: 2] = c.mode;
    v[EN_BIT]        = c.run_en;
    return v;
  endfunction

  function automatic ctrl_t ctrl_unpack(logic [CTRL_W-1:0] w);
    ctrl_t c;
    c.mode   = tmode_e'(w[MODE_LSB +: 2]);
    c.run_en = w[EN_BIT];
    return c;
  endfunction

  function automatic logic ctrl_counting(ctrl_t c);
    return c.run_en && (c.mode == MODE_TIMER);
  endfunction

endpackage

// File: rtl/tmr_ctrl.sv
module tmr_ctrl
  import tmr_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_strobe,
  input  logic [CTRL_W-1:0] wdata,
  output ctrl_t             ctrl_q,
  output logic [CTRL_W-1:0] rd_word,
  output logic              counting
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q <= '0;
    end else if (wr_strobe) begin
      ctrl_q <= ctrl_unpack(wdata);
    end
  end

  assign rd_word  = ctrl_pack(ctrl_q);
  assign counting = ctrl_counting(ctrl_q);

  AST_CTRL_STOP_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_strobe && !wdata[EN_BIT]) |=> !counting); // R5

  AST_CTRL_MODE_GATE: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_strobe && (wdata[MODE_LSB +: 2] != 2'b10)) |=> !counting); // R6

endmodule

// File: rtl/tmr_prescale.sv
module tmr_prescale #(
  parameter int DIV = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  output logic tick
);

  localparam int PS_W = (DIV > 2) ? $clog2(DIV) : 1;
  localparam logic [PS_W-1:0] PS_LAST = PS_W'(DIV - 1);

  logic [PS_W-1:0] ps_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ps_q <= '0;
    end else if (!run) begin
      ps_q <= '0;
    end else if (ps_q == PS_LAST) begin
      ps_q <= '0;
    end else begin
      ps_q <= ps_q + 1'b1;
    end
  end

  assign tick = run && (ps_q == PS_LAST);

  AST_TICK_GAP: assert property (@(posedge clk) disable iff (!rst_n)
    tick |=> !tick); // R2

  AST_PS_IDLE_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
    !run |=> !tick); // R5

endmodule

// File: rtl/tmr_core.sv
module tmr_core #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         tick,
  input  logic         pre_wr,
  input  logic [W-1:0] pre_wdata,
  input  logic         irq_clr,
  output logic [W-1:0] count,
  output logic         irq_flag,
  output logic         wrap_evt
);

  localparam logic [W-1:0] CNT_MAX = '1;

  logic [W-1:0] preload_q;

  function automatic logic [W-1:0] next_count(logic [W-1:0] cur, logic [W-1:0] rel);
    return (cur == CNT_MAX) ? rel : cur + 1'b1;
  endfunction

  assign wrap_evt = tick && (count == CNT_MAX);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      preload_q <= '0;
    end else if (pre_wr) begin
      preload_q <= pre_wdata;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      count <= '0;
    end else if (tick) begin
      count <= next_count(count, preload_q);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      irq_flag <= 1'b0;
    end else if (wrap_evt) begin
      irq_flag <= 1'b1;
    end else if (irq_clr) begin
      irq_flag <= 1'b0;
    end
  end

  AST_PRELOAD_NO_TOUCH: assert property (@(posedge clk) disable iff (!rst_n)
    (pre_wr && !tick) |=> (count == $past(count))); // R3

  AST_STEP_ONE: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && !wrap_evt) |=> (count == $past(count) + W'(1))); // R2

  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !tick |=> $stable(count)); // R5

  AST_WRAP_RELOAD: assert property (@(posedge clk) disable iff (!rst_n)
    wrap_evt |=> ((count == $past(preload_q)) && irq_flag)); // R4

  AST_FLAG_ONLY_ON_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
    (!irq_flag && !wrap_evt) |=> !irq_flag); // R4

  AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_flag && !irq_clr) |=> irq_flag); // R7

  AST_WRAP_BEATS_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    (wrap_evt && irq_clr) |=> irq_flag); // R7

endmodule

// File: rtl/reload_timer8.sv
module reload_timer8
  import tmr_pkg::*;
#(
  parameter int W   = 8,
  parameter int DIV = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         bus_addr,
  input  logic         bus_wr,
  input  logic [W-1:0] bus_wdata,
  output logic [W-1:0] bus_rdata,
  input  logic         irq_clr,
  output logic         irq_flag
);

  ctrl_t              ctrl_q;
  logic [CTRL_W-1:0]  ctrl_word;
  logic               counting;
  logic               tick;
  logic               wrap_evt;
  logic [W-1:0]       count;
  logic               ctrl_wr;
  logic               data_wr;

  assign ctrl_wr = bus_wr && bus_addr;
  assign data_wr = bus_wr && !bus_addr;

  tmr_ctrl u_ctrl (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_strobe(ctrl_wr),
    .wdata    (bus_wdata[CTRL_W-1:0]),
    .ctrl_q   (ctrl_q),
    .rd_word  (ctrl_word),
    .counting (counting)
  );

  tmr_prescale #(.DIV(DIV)) u_ps (
    .clk  (clk),
    .rst_n(rst_n),
    .run  (counting),
    .tick (tick)
  );

  tmr_core #(.W(W)) u_core (
    .clk      (clk),
    .rst_n    (rst_n),
    .tick     (tick),
    .pre_wr   (data_wr),
    .pre_wdata(bus_wdata),
    .irq_clr  (irq_clr),
    .count    (count),
    .irq_flag (irq_flag),
    .wrap_evt (wrap_evt)
  );

  assign bus_rdata = bus_addr ? W'(ctrl_word) : count;

  AST_CTRL_SPARE_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    bus_addr |-> ((bus_rdata[CTRL_W-1:0] & 8'h2F) == 8'h00)); // R8

  AST_MODE_FREEZE: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl_q.mode != MODE_TIMER) |=> $stable(count)); // R6

endmodule

// File: tb/reload_timer8_test.sv
module reload_timer8_test;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       bus_addr = 1'b0;
  logic       bus_wr = 1'b0;
  logic [7:0] bus_wdata = '0;
  logic [7:0] bus_rdata;
  logic       irq_clr = 1'b0;
  logic       irq_flag;

  int n_chk = 0;
  int n_bad = 0;

  // independent model of the requirements
  logic [7:0] m_cnt = '0, m_pre = '0;
  logic [1:0] m_mode = '0;
  logic       m_en = 1'b0, m_flag = 1'b0;
  int         m_ps = 0;

  always #10 clk = ~clk;

  reload_timer8 uut (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq_clr(irq_clr), .irq_flag(irq_flag)
  );

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %02h expected %02h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] ctrl_exp();
    return {m_mode, 1'b0, m_en, 4'b0000};
  endfunction

  // one clock: inputs driven at negedge, model updated at posedge
  task automatic step(input logic wr, input logic addr, input logic [7:0] d, input logic clr);
    logic run, tck;
    bus_wr = wr; bus_addr = addr; bus_wdata = d; irq_clr = clr;
    @(posedge clk);
    run = m_en && (m_mode == 2'b10);
    tck = run && (m_ps == 3);
    if (tck && m_cnt == 8'hFF) begin
      m_cnt = m_pre; m_flag = 1'b1;
    end else begin
      if (tck) m_cnt = m_cnt + 8'd1;
      if (clr) m_flag = 1'b0;
    end
    m_ps = run ? (m_ps + 1) % 4 : 0;
    if (wr && addr) begin m_mode = d[7:6]; m_en = d[4]; end
    if (wr && !addr) m_pre = d;
    @(negedge clk);
    bus_wr = 1'b0; irq_clr = 1'b0;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) step(1'b0, 1'b0, 8'h00, 1'b0);
  endtask

  task automatic read_cnt(output logic [7:0] v);
    bus_addr = 1'b0; #1; v = bus_rdata;
  endtask

  task automatic read_ctrl(output logic [7:0] v);
    bus_addr = 1'b1; #1; v = bus_rdata;
  endtask

  task automatic cmp_model(input string req);
    logic [7:0] v;
    read_cnt(v);  chk({req, " count vs model"}, v, m_cnt);
    read_ctrl(v); chk({req, " ctrl vs model"}, v, ctrl_exp());
    chk({req, " flag vs model"}, {7'b0, irq_flag}, {7'b0, m_flag});
  endtask

  task automatic run_to_prewrap();
    while (!(m_cnt == 8'hFF && m_ps == 3)) idle(1);
  endtask

  task automatic t_reset();
    logic [7:0] v;
    read_cnt(v);  chk("R1 count after reset", v, 8'h00);
    read_ctrl(v); chk("R1 ctrl after reset", v, 8'h00);
    chk("R1 flag after reset", {7'b0, irq_flag}, 8'h00);
    idle(6);
    read_cnt(v);  chk("R1 timer stays off", v, 8'h00);
  endtask

  task automatic t_ctrl_fields();
    logic [7:0] v;
    step(1'b1, 1'b1, 8'hFF, 1'b0);
    read_ctrl(v); chk("R8 ctrl readback of FF", v, 8'hD0);
    idle(12);
    read_cnt(v); chk("R6 mode 11 holds count", v, 8'h00);
    step(1'b1, 1'b1, 8'h5F, 1'b0);
    read_ctrl(v); chk("R8 ctrl readback of 5F", v, 8'h50);
    idle(12);
    read_cnt(v); chk("R6 mode 01 holds count", v, 8'h00);
    step(1'b1, 1'b1, 8'h80, 1'b0);
    idle(12);
    read_cnt(v); chk("R5 enable low holds count", v, 8'h00);
    cmp_model("R8");
  endtask

  task automatic t_prescale();
    logic [7:0] v;
    step(1'b1, 1'b0, 8'hFD, 1'b0);
    read_cnt(v); chk("R3 data write leaves count", v, 8'h00);
    step(1'b1, 1'b1, 8'h90, 1'b0);
    idle(3);
    read_cnt(v); chk("R2 no step before 4th edge", v, 8'h00);
    idle(1);
    read_cnt(v); chk("R2 first step on 4th edge", v, 8'h01);
    idle(4);
    read_cnt(v); chk("R2 second step 4 edges later", v, 8'h02);
  endtask

  task automatic t_pause();
    logic [7:0] v;
    idle(2);
    step(1'b1, 1'b1, 8'h80, 1'b0);
    idle(5);
    read_cnt(v); chk("R5 paused count holds", v, 8'h02);
    step(1'b1, 1'b1, 8'h90, 1'b0);
    idle(3);
    read_cnt(v); chk("R5 prescaler restarted", v, 8'h02);
    idle(1);
    read_cnt(v); chk("R5 step on 4th edge after resume", v, 8'h03);
    cmp_model("R5");
  endtask

  task automatic t_overflow();
    logic [7:0] v;
    run_to_prewrap();
    read_cnt(v); chk("R4 count at FF before wrap", v, 8'hFF);
    chk("R4 flag low before wrap", {7'b0, irq_flag}, 8'h00);
    idle(1);
    read_cnt(v); chk("R4 reload value after wrap", v, 8'hFD);
    chk("R4 flag set on wrap edge", {7'b0, irq_flag}, 8'h01);
    idle(4);
    read_cnt(v); chk("R4 counting resumes from reload", v, 8'hFE);
    idle(8);
    read_cnt(v); chk("R4 second wrap reloads", v, 8'hFD);
    chk("R7 flag still set without clear", {7'b0, irq_flag}, 8'h01);
    cmp_model("R4");
  endtask

  task automatic t_clear();
    logic [7:0] v;
    step(1'b0, 1'b0, 8'h00, 1'b1);
    chk("R7 clear strobe drops flag", {7'b0, irq_flag}, 8'h00);
    run_to_prewrap();
    step(1'b0, 1'b0, 8'h00, 1'b1);
    chk("R7 wrap wins over clear", {7'b0, irq_flag}, 8'h01);
    step(1'b0, 1'b0, 8'h00, 1'b1);
    step(1'b1, 1'b0, 8'h10, 1'b0);
    read_cnt(v); chk("R3 reload write mid-count leaves count", v, m_cnt);
    run_to_prewrap();
    idle(1);
    read_cnt(v); chk("R4 new reload value used", v, 8'h10);
    cmp_model("R7");
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_ctrl_fields();
    t_prescale();
    t_pause();
    t_overflow();
    t_clear();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

endmodule